// File: doc/BRIEF.md
# Half-Step Phase-Slip Oscillator

This block is the oscillator stage of an all-digital phase-locked loop. It runs on a fast reference clock at 2N times the wanted centre frequency and keeps a toggle state that normally inverts on every rising clock edge. The intermediate output is formed as the inverted clock ANDed with the inverted toggle state. With no correction pending, this gives one pulse during the low phase of every second clock cycle, which is the clock divided by two.

Upstream loop logic steers the phase with two request lines, `carry_in` and `borrow_in`. Each rising edge on one of them is stored as a signed pending request. A carry inserts one extra half cycle of the intermediate output: the toggle state is held low for one extra clock, which produces an additional pulse. A borrow deletes one half cycle: the toggle state is held high for one extra clock, which removes a pulse.

A divide-by-N counter counts the pulses of the intermediate output and produces the final oscillator output. Only one correction is applied per output period. Requests that cannot be applied yet stay pending, up to a saturating limit.

Top module: `idc_dco`

## Requirements
- R1: While `rst_n` is low and afterwards until the first rising edge, the toggle state is 0, nothing is pending and the divider count is 0. During the clock low phase `id_out` reads 1, and `dco_out` reads 1.
- R2: With nothing pending, the toggle state inverts on every rising edge of `clk`. `id_out` equals (NOT `clk`) AND (NOT toggle), so it is high in the low phase of every second clock cycle.
- R3: A rising edge on `carry_in` adds +1 to the pending count. A positive pending count is applied at a rising edge where the toggle state is 0 and the previous edge toggled: the state is held at 0 for one extra cycle (one extra `id_out` pulse), and the pending count drops by 1.
- R4: A rising edge on `borrow_in` adds -1 to the pending count. A negative pending count is applied at a rising edge where the toggle state is 1 and the previous edge toggled: the state is held at 1 for one extra cycle (one `id_out` pulse removed), and the pending count rises by 1.
- R5: A request line held high for several cycles counts as a single request. Only a 0-to-1 change between consecutive clock samples is an edge.
- R6: A carry edge and a borrow edge sampled at the same clock edge cancel each other, and the timing of `id_out` is unchanged.
- R7: After a correction, the next rising edge always toggles. Requests in excess of one stay pending and are applied at later opportunities.
- R8: The pending count saturates at +(2^(PEND_W-1)-1) and at -(2^(PEND_W-1)-1). Edges that would push it beyond the limit are ignored, which shows as fewer corrections on `id_out`.
- R9: At each rising edge where the toggle state was 0 (one `id_out` pulse), the divider count steps by one and wraps from DIV_N-1 to 0. `dco_out` is 1 while the count is below DIV_N/2 (rounded down), so the duty cycle is 50% in pulses for even DIV_N.
- R10: An edge sampled at a rising clock edge can be applied no earlier than the following rising edge.
- R11: For a DIV_N that is not a power of two (for example 5), the count still wraps at DIV_N-1, and `dco_out` is 1 for counts 0 to DIV_N/2-1 (rounded down).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, 2N times the centre frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| carry_in | input | 1 | Phase advance request, acting on its rising edge |
| borrow_in | input | 1 | Phase retard request, acting on its rising edge |
| id_out | output | 1 | Intermediate output: NOT clk AND NOT toggle state |
| dco_out | output | 1 | Final output, divided by DIV_N |

## Verification
The properties assume that `carry_in` and `borrow_in` are synchronous to `clk` and stable around its rising edge. They also assume that both lines are low when reset is released, so that no request is seen during reset. The bench changes the request lines only shortly after a falling clock edge, and it releases reset with both lines low. Bursts of requests are driven faster than the block can apply them, so that holding, cancelling and saturation of pending requests are all exercised while staying inside these assumptions.

// File: rtl/idc_pkg.sv
`timescale 1ns/1ps
package idc_pkg;
   // Correction chosen for the current rising edge
   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_ADD  = 2'd1,
      ACT_DROP = 2'd2
   } idc_act_e;

   // Width for a counter holding 0 .. n-1, never below one bit
   function automatic int idc_cw(input int n);
      int w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

   function automatic bit idc_is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/idc_edge.sv
`timescale 1ns/1ps
module idc_edge #(
   parameter int CH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CH-1:0] lvl,
   output logic [CH-1:0] rise
);
   for (genvar g = 0; g < CH; g++) begin : g_ch
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl[g];
      end
      assign rise[g] = lvl[g] & ~prev_q;
   end
endmodule

// File: rtl/idc_pend.sv
`timescale 1ns/1ps
module idc_pend import idc_pkg::*; #(
   parameter int PEND_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     up_req,
   input  logic                     dn_req,
   input  idc_act_e                 act,
   output logic signed [PEND_W-1:0] pend,
   output logic                     want_add,
   output logic                     want_drop
);
   localparam int SW = PEND_W + 2;
   localparam logic signed [SW-1:0] ONE    = SW'(1);
   localparam logic signed [SW-1:0] LIM_HI = SW'((1 << (PEND_W - 1)) - 1);
   localparam logic signed [SW-1:0] LIM_LO = -LIM_HI;

   logic signed [SW-1:0] nxt;

   always_comb begin
      nxt = SW'(pend);
      if (up_req && !dn_req) nxt = nxt + ONE;
      if (dn_req && !up_req) nxt = nxt - ONE;
      if (act == ACT_ADD)    nxt = nxt - ONE;
      if (act == ACT_DROP)   nxt = nxt + ONE;
      if (nxt > LIM_HI)      nxt = LIM_HI;
      if (nxt < LIM_LO)      nxt = LIM_LO;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= nxt[PEND_W-1:0];
   end

   assign want_drop = pend[PEND_W-1];
   assign want_add  = !pend[PEND_W-1] && (pend != '0);
endmodule

// File: rtl/idc_tog.sv
`timescale 1ns/1ps
module idc_tog import idc_pkg::*; (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     want_add,
   input  logic     want_drop,
   output logic     tff,
   output logic     held,
   output idc_act_e act
);
   always_comb begin
      act = ACT_NONE;
      if (!held) begin
         if (!tff && want_add)     act = ACT_ADD;
         else if (tff && want_drop) act = ACT_DROP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tff  <= 1'b0;
         held <= 1'b0;
      end else begin
         held <= (act != ACT_NONE);
         if (act == ACT_NONE) tff <= ~tff;
      end
   end
endmodule

// File: rtl/idc_div.sv
`timescale 1ns/1ps
module idc_div import idc_pkg::*; #(
   parameter int DIV_N = 4,
   localparam int CW = idc_cw(DIV_N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [CW-1:0] cnt,
   output logic          dco_out
);
   localparam logic [CW-1:0] LAST = CW'(DIV_N - 1);
   localparam logic [CW-1:0] HALF = CW'(DIV_N / 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (step)      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   if (idc_is_pow2(DIV_N)) begin : g_pow2
      assign dco_out = ~cnt[CW-1];
   end else begin : g_cmp
      assign dco_out = (cnt < HALF);
   end
endmodule

// File: rtl/idc_dco.sv
`timescale 1ns/1ps
module idc_dco import idc_pkg::*; #(
   parameter int DIV_N  = 4,
   parameter int PEND_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic carry_in,
   input  logic borrow_in,
   output logic id_out,
   output logic dco_out
);
   localparam int CW = idc_cw(DIV_N);

   if (DIV_N < 2)  begin : g_bad_n
      $error("idc_dco: DIV_N must be at least 2");
   end
   if (PEND_W < 2) begin : g_bad_w
      $error("idc_dco: PEND_W must be at least 2");
   end

   logic [1:0]               rise;
   logic signed [PEND_W-1:0] pend;
   logic                     want_add;
   logic                     want_drop;
   logic                     tff;
   logic                     held;
   idc_act_e                 act;
   logic [CW-1:0]            cnt;

   idc_edge #(.CH(2)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  ({borrow_in, carry_in}),
      .rise (rise)
   );

   idc_pend #(.PEND_W(PEND_W)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_req   (rise[0]),
      .dn_req   (rise[1]),
      .act      (act),
      .pend     (pend),
      .want_add (want_add),
      .want_drop(want_drop)
   );

   idc_tog u_tog (
      .clk      (clk),
      .rst_n    (rst_n),
      .want_add (want_add),
      .want_drop(want_drop),
      .tff      (tff),
      .held     (held),
      .act      (act)
   );

   idc_div #(.DIV_N(DIV_N)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (~tff),
      .cnt    (cnt),
      .dco_out(dco_out)
   );

   assign id_out = ~clk & ~tff;
endmodule

// File: rtl/idc_dco_chk.sv
`timescale 1ns/1ps
module idc_dco_chk #(
   parameter int DIV_N  = 4,
   parameter int PEND_W = 4,
   localparam int CW = idc_pkg::idc_cw(DIV_N)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     tff,
   input logic                     held,
   input logic signed [PEND_W-1:0] pend,
   input logic [CW-1:0]            cnt
);
   localparam logic [PEND_W-1:0] PMAX = PEND_W'((1 << (PEND_W - 1)) - 1);
   logic pos_w;
   logic neg_w;
   assign pos_w = !pend[PEND_W-1] && (pend != '0);
   assign neg_w = pend[PEND_W-1];

   AST_NO_DOUBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(tff) |=> !$stable(tff)); // R7

   AST_ADD_NEEDS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      !tff |=> (tff || $past(pos_w))); // R3

   AST_DROP_NEEDS_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
      tff |=> (!tff || $past(neg_w))); // R4

   AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (pend != $signed(-PEND_W'(1 << (PEND_W - 1))))); // R8

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(cnt) < DIV_N)); // R9

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tff |=> $stable(cnt)); // R9

   AST_CNT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      !tff |=> !$stable(cnt)); // R9

   AST_HELD_MEANS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> $stable(tff)); // R3

   initial begin
      AST_PMAX_POS: assert (PMAX != '0); // R8
   end
endmodule

bind idc_dco idc_dco_chk #(.DIV_N(DIV_N), .PEND_W(PEND_W)) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .tff  (tff),
   .held (held),
   .pend (pend),
   .cnt  (cnt)
);

// File: tb/sim_idc_dco.sv
`timescale 1ns/1ps
module sim_idc_dco;
   localparam int N0   = 4;
   localparam int N1   = 5;
   localparam int PW   = 3;
   localparam int PMAX = (1 << (PW - 1)) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic carry_in = 1'b0;
   logic borrow_in = 1'b0;
   logic id0, dco0, id1, dco1;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   run = 0;
   string tag = "R2";

   always #2.5 clk = ~clk;

   idc_dco #(.DIV_N(N0), .PEND_W(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .carry_in(carry_in), .borrow_in(borrow_in),
      .id_out(id0), .dco_out(dco0));

   idc_dco #(.DIV_N(N1), .PEND_W(PW)) u1 (
      .clk(clk), .rst_n(rst_n), .carry_in(carry_in), .borrow_in(borrow_in),
      .id_out(id1), .dco_out(dco1));

   // behavioural reference
   int m_pend, m_cnt0, m_cnt1;
   bit m_tff, m_held, m_cp, m_bp;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pend = 0; m_cnt0 = 0; m_cnt1 = 0;
         m_tff = 0; m_held = 0; m_cp = 0; m_bp = 0;
      end else begin
         bit rc, rb, ac, ab, t_old;
         rc = carry_in && !m_cp;
         rb = borrow_in && !m_bp;
         ac = !m_tff && !m_held && (m_pend > 0);
         ab = m_tff && !m_held && (m_pend < 0);
         t_old = m_tff;
         if (ac || ab) m_held = 1;
         else begin m_tff = !m_tff; m_held = 0; end
         if (rc && !rb) m_pend++;
         if (rb && !rc) m_pend--;
         if (ac) m_pend--;
         if (ab) m_pend++;
         if (m_pend > PMAX)  m_pend = PMAX;
         if (m_pend < -PMAX) m_pend = -PMAX;
         if (!t_old) begin
            m_cnt0 = (m_cnt0 + 1) % N0;
            m_cnt1 = (m_cnt1 + 1) % N1;
         end
         m_cp = carry_in;
         m_bp = borrow_in;
      end
   end

   task automatic check(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (run) begin
         #1;
         check(id0, !m_tff, tag);
         check(dco0, m_cnt0 < N0 / 2, "R9");
         check(id1, !m_tff, tag);
         check(dco1, m_cnt1 < N1 / 2, "R11");
      end
   end

   task automatic step(input logic c, input logic b);
      @(negedge clk);
      #2;
      carry_in  = c;
      borrow_in = b;
   endtask

   task automatic idle(input int n);
      repeat (n) step(1'b0, 1'b0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      #1;
      check(id0, 1'b1, "R1");
      check(dco0, 1'b1, "R1");
      check(id1, 1'b1, "R1");
      check(dco1, 1'b1, "R1");
      #1;
      rst_n = 1'b1;
      run   = 1;
      tag = "R1 R2"; idle(2);
      tag = "R2";    idle(20);
      tag = "R3 R10"; step(1, 0); idle(10);
      tag = "R4 R10"; step(0, 1); idle(10);
      tag = "R5"; repeat (8) step(1, 0); idle(6);
      repeat (8) step(0, 1); idle(10);
      tag = "R6"; step(1, 1); idle(10);
      step(1, 0); step(1, 1); step(0, 1); idle(10);
      tag = "R7"; repeat (3) begin step(1, 0); step(0, 0); end idle(20);
      repeat (3) begin step(0, 1); step(0, 0); end idle(20);
      tag = "R8"; repeat (16) begin step(1, 0); step(0, 0); end idle(30);
      repeat (16) begin step(0, 1); step(0, 0); end idle(30);
      tag = "R9 R11"; idle(40);
      @(negedge clk);
      #2;
      run = 0;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule